// File: doc/BRIEF.md
# Bell and Bong Chime Generator

This block makes two sound effects on command from a processor and gives each one as a digital amplitude word. Both take their timing from a horizontal sync strobe, a single-cycle pulse that is synchronous to the system clock. The bell is armed while its control input is high. While armed, its amplitude envelope is loaded to full scale and its tone divider is held at zero. When the control input falls, the divider starts counting sync pulses and gives a square tone at one sixteenth of the sync rate. At the same time the envelope starts to decay geometrically. The bell output shows the envelope value while the tone is high and zero while it is low.

The bong is a lower fixed tone. It sounds at a constant level for as long as its control input is high. An attract-mode mute forces both outputs to zero. The mute does not disturb any timing state, so a bell that is decaying keeps decaying underneath it. Mixing and digital-to-analog conversion happen downstream.

Top module: `chime_fx`

## Requirements
- R1: After reset both `bell_amp` and `bong_amp` are zero.
- R2: While `bell_arm` is high, `bell_amp` is zero, the envelope is held at all ones (255 by default), and the tone divider is held at zero.
- R3: Once `bell_arm` is low, the divider counts `hsync_pulse` strobes modulo 2^DIV_W (16 by default). The tone is high while the count is in the upper half (8..15 by default), so the first high phase begins on the eighth strobe after release.
- R4: `bell_amp` equals the envelope when `bell_arm` is low and the tone is high, and is zero otherwise.
- R5: While `bell_arm` is low, every DECAY_TICK strobes the envelope is reduced by envelope >> DECAY_SHIFT. The reduction is at least 1 while the envelope is nonzero. Once the envelope reaches zero it stays at zero.
- R6: Raising `bell_arm` again during a decay reloads the envelope to full scale and restarts both the divider and the decay tick count from zero.
- R7: While `bong_on` is high, a square wave starts low and toggles every BONG_HALF strobes. `bong_amp` is BONG_LEVEL while the square is high and zero while it is low.
- R8: While `bong_on` is low, `bong_amp` is zero and the bong phase is cleared.
- R9: While `attract_mute` is high, both outputs are zero. Divider, envelope and bong phase advance exactly as they would without the mute.
- R10: Clock cycles without `hsync_pulse` change neither the divider, the decay tick count nor the bong phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_pulse | input | 1 | One-cycle horizontal sync strobe |
| bell_arm | input | 1 | Bell control; high arms, falling edge starts the chime |
| bong_on | input | 1 | Bong control; tone sounds while high |
| attract_mute | input | 1 | Forces both outputs to zero |
| bell_amp | output | AMP_W | Bell amplitude word |
| bong_amp | output | AMP_W | Bong amplitude word |

## Verification
The hardest case to reach is the late tail of the decay. There the shifted reduction is zero and only the minimum step of one moves the envelope. It must then settle at zero without wrapping around. The bench gets there by shortening the decay tick through a parameter and running well over a thousand sync strobes after one release, with the tone sampled in every high phase. A rearm part-way through a decay and a mute placed across a decay boundary are also driven. The scoreboard carries the same envelope through these, so any lost or extra decay step shows up when the output returns.

// File: rtl/chime_pkg.sv
package chime_pkg;
   // width of a counter that must hold 0 .. n-1, never below one bit
   function automatic int cnt_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/chime_div.sv
module chime_div #(
   parameter int DIV_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hsync,
   input  logic hold,
   output logic tone
);
   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (hold)  cnt_q <= '0;
      else if (hsync) cnt_q <= cnt_q + 1'b1;
   end

   assign tone = cnt_q[DIV_W-1];
endmodule

// File: rtl/chime_env.sv
module chime_env #(
   parameter int AMP_W       = 8,
   parameter int DECAY_TICK  = 983,
   parameter int DECAY_SHIFT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hsync,
   input  logic             charge,
   output logic [AMP_W-1:0] env
);
   localparam int TW = chime_pkg::cnt_w(DECAY_TICK);
   localparam logic [TW-1:0] TICK_LAST = TW'(DECAY_TICK - 1);

   logic [TW-1:0]    tick_q;
   logic [AMP_W-1:0] env_q;
   logic [AMP_W-1:0] drop;

   // geometric step, with a floor of one so the tail reaches zero
   always_comb begin
      drop = env_q >> DECAY_SHIFT;
      if (drop == '0 && env_q != '0) drop = AMP_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         env_q  <= '0;
         tick_q <= '0;
      end else if (charge) begin
         env_q  <= '1;
         tick_q <= '0;
      end else if (hsync) begin
         if (tick_q == TICK_LAST) begin
            tick_q <= '0;
            env_q  <= env_q - drop;
         end else begin
            tick_q <= tick_q + 1'b1;
         end
      end
   end

   assign env = env_q;
endmodule

// File: rtl/chime_osc.sv
module chime_osc #(
   parameter int BONG_HALF = 31
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hsync,
   input  logic run,
   output logic sq
);
   logic sq_q;

   generate
      if (BONG_HALF == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sq_q <= 1'b0;
            else if (!run)  sq_q <= 1'b0;
            else if (hsync) sq_q <= ~sq_q;
         end
      end else begin : g_count
         localparam int PW = chime_pkg::cnt_w(BONG_HALF);
         localparam logic [PW-1:0] PH_LAST = PW'(BONG_HALF - 1);
         logic [PW-1:0] ph_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ph_q <= '0;
               sq_q <= 1'b0;
            end else if (!run) begin
               ph_q <= '0;
               sq_q <= 1'b0;
            end else if (hsync) begin
               if (ph_q == PH_LAST) begin
                  ph_q <= '0;
                  sq_q <= ~sq_q;
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
            end
         end
      end
   endgenerate

   assign sq = sq_q;
endmodule

// File: rtl/chime_fx.sv
module chime_fx #(
   parameter int AMP_W       = 8,
   parameter int DIV_W       = 4,
   parameter int DECAY_TICK  = 983,
   parameter int DECAY_SHIFT = 4,
   parameter int BONG_HALF   = 31,
   parameter int BONG_LEVEL  = 160
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hsync_pulse,
   input  logic             bell_arm,
   input  logic             bong_on,
   input  logic             attract_mute,
   output logic [AMP_W-1:0] bell_amp,
   output logic [AMP_W-1:0] bong_amp
);
   localparam logic [AMP_W-1:0] BONG_WORD = AMP_W'(BONG_LEVEL);

   generate
      if (AMP_W < 2)                        begin : g_bad_amp   $error("AMP_W must be at least 2"); end
      if (DIV_W < 2)                        begin : g_bad_div   $error("DIV_W must be at least 2"); end
      if (DECAY_TICK < 1)                   begin : g_bad_tick  $error("DECAY_TICK must be positive"); end
      if (DECAY_SHIFT < 1 || DECAY_SHIFT >= AMP_W) begin : g_bad_shift $error("DECAY_SHIFT out of range"); end
      if (BONG_HALF < 1)                    begin : g_bad_half  $error("BONG_HALF must be positive"); end
      if (BONG_LEVEL < 1 || BONG_LEVEL >= (1 << AMP_W)) begin : g_bad_lvl $error("BONG_LEVEL out of range"); end
   endgenerate

   logic             tone;
   logic             bong_sq;
   logic [AMP_W-1:0] env_lvl;

   chime_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .hsync(hsync_pulse), .hold(bell_arm), .tone(tone)
   );

   chime_env #(.AMP_W(AMP_W), .DECAY_TICK(DECAY_TICK), .DECAY_SHIFT(DECAY_SHIFT)) u_env (
      .clk(clk), .rst_n(rst_n), .hsync(hsync_pulse), .charge(bell_arm), .env(env_lvl)
   );

   chime_osc #(.BONG_HALF(BONG_HALF)) u_osc (
      .clk(clk), .rst_n(rst_n), .hsync(hsync_pulse), .run(bong_on), .sq(bong_sq)
   );

   always_comb begin
      bell_amp = '0;
      bong_amp = '0;
      if (!attract_mute) begin
         if (!bell_arm && tone) bell_amp = env_lvl;
         if (bong_on && bong_sq) bong_amp = BONG_WORD;
      end
   end
endmodule

// File: rtl/chime_fx_chk.sv
module chime_fx_chk #(
   parameter int AMP_W      = 8,
   parameter int BONG_LEVEL = 160
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bell_arm,
   input logic             bong_on,
   input logic             attract_mute,
   input logic [AMP_W-1:0] env_lvl,
   input logic [AMP_W-1:0] bell_amp,
   input logic [AMP_W-1:0] bong_amp
);
   // R2
   armed_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bell_arm |-> bell_amp == '0);
   // R2
   armed_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bell_arm |=> env_lvl == '1);
   // R4
   bell_follows_env_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bell_amp != '0 |-> bell_amp == env_lvl);
   // R5
   env_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bell_arm |=> env_lvl <= $past(env_lvl));
   // R7
   bong_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bong_amp == '0 || bong_amp == AMP_W'(BONG_LEVEL));
   // R8
   bong_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bong_on |-> bong_amp == '0);
   // R9
   mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      attract_mute |-> (bell_amp == '0 && bong_amp == '0));
endmodule

bind chime_fx chime_fx_chk #(.AMP_W(AMP_W), .BONG_LEVEL(BONG_LEVEL)) u_chk (
   .clk(clk), .rst_n(rst_n), .bell_arm(bell_arm), .bong_on(bong_on),
   .attract_mute(attract_mute), .env_lvl(env_lvl),
   .bell_amp(bell_amp), .bong_amp(bong_amp)
);

// File: tb/chime_fx_bench.sv
module chime_fx_bench;
   localparam int AMP_W = 8, DIV_W = 4, TICK = 12, SHIFT = 4, HALF = 3, LEVEL = 160;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hsync_pulse = 1'b0, bell_arm = 1'b0, bong_on = 1'b0, attract_mute = 1'b0;
   logic [AMP_W-1:0] bell_amp, bong_amp;

   always #10 clk = ~clk;

   chime_fx #(.AMP_W(AMP_W), .DIV_W(DIV_W), .DECAY_TICK(TICK), .DECAY_SHIFT(SHIFT),
              .BONG_HALF(HALF), .BONG_LEVEL(LEVEL)) u_chime_fx (
      .clk(clk), .rst_n(rst_n), .hsync_pulse(hsync_pulse), .bell_arm(bell_arm),
      .bong_on(bong_on), .attract_mute(attract_mute), .bell_amp(bell_amp), .bong_amp(bong_amp)
   );

   typedef struct {
      logic [AMP_W-1:0] bell;
      logic [AMP_W-1:0] bong;
      string            tag;
   } item_t;

   item_t q[$];
   int compared = 0, mismatched = 0;
   string cur_req = "R1";
   bit done = 0;

   // reference state
   logic [DIV_W-1:0] m_cnt = '0;
   logic [AMP_W-1:0] m_env = '0;
   int m_tick = 0, m_ph = 0;
   logic m_sq = 1'b0;

   task automatic check(input string tag, input logic [AMP_W-1:0] act, input logic [AMP_W-1:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input bit b, input bit g, input bit m, input bit h);
      item_t it;
      logic [AMP_W-1:0] drop;
      @(negedge clk);
      bell_arm = b; bong_on = g; attract_mute = m; hsync_pulse = h;
      if (b) begin
         m_cnt = '0; m_env = '1; m_tick = 0;
      end else if (h) begin
         m_cnt = m_cnt + 1'b1;
         if (m_tick == TICK - 1) begin
            m_tick = 0;
            drop = m_env >> SHIFT;
            if (drop == 0 && m_env != 0) drop = 1;
            m_env = m_env - drop;
         end else m_tick++;
      end
      if (!g) begin
         m_ph = 0; m_sq = 1'b0;
      end else if (h) begin
         if (m_ph == HALF - 1) begin m_ph = 0; m_sq = ~m_sq; end
         else m_ph++;
      end
      it.bell = (!m && !b && m_cnt[DIV_W-1]) ? m_env : '0;
      it.bong = (!m && g && m_sq) ? AMP_W'(LEVEL) : '0;
      it.tag  = cur_req;
      q.push_back(it);
   endtask

   // monitor: compare one item per clock edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check({it.tag, " bell"}, bell_amp, it.bell);
            check({it.tag, " bong"}, bong_amp, it.bong);
         end
      end
   end

   initial begin
      #4000000;
      if (!done) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      bit saw_full;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 bell", bell_amp, '0);
      check("R1 bong", bong_amp, '0);
      rst_n = 1'b1;
      cur_req = "R1";
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0);

      // R7 bong toggling, R8 off
      cur_req = "R7";
      for (int i = 0; i < 40; i++) step(0, 1, 0, i % 2);
      cur_req = "R8";
      for (int i = 0; i < 10; i++) step(0, 0, 0, i % 2);

      // R2 armed
      cur_req = "R2";
      for (int i = 0; i < 12; i++) step(1, 0, 0, i % 2);
      // R3/R4 first tone periods after release; R2 full scale in first high phase
      cur_req = "R3";
      saw_full = 0;
      for (int i = 0; i < 40; i++) begin
         step(0, 0, 0, i % 2);
         if (m_cnt[DIV_W-1] && m_env == 8'hFF) saw_full = 1;
      end
      compared++;
      if (!saw_full) begin
         mismatched++;
         $display("FAIL R2: actual no full-scale phase expected 255 in first high phase");
      end

      // R4/R5 decay with bong running
      cur_req = "R5";
      for (int i = 0; i < 300; i++) step(0, 1, 0, i % 2);

      // R6 rearm mid decay
      cur_req = "R6";
      for (int i = 0; i < 3; i++) step(1, 0, 0, 1);
      for (int i = 0; i < 120; i++) step(0, 0, 0, 1);

      // R9 mute across a decay boundary, then unmute
      cur_req = "R9";
      for (int i = 0; i < 70; i++) step(0, 1, 1, i % 2);
      cur_req = "R4";
      for (int i = 0; i < 70; i++) step(0, 1, 0, i % 2);

      // R10 idle cycles without sync
      cur_req = "R10";
      for (int i = 0; i < 30; i++) step(0, 1, 0, 0);

      // R5 tail: run to zero
      cur_req = "R5";
      for (int i = 0; i < 1600; i++) step(0, 0, 0, 1);
      compared++;
      if (m_env != 0) begin
         mismatched++;
         $display("FAIL R5: actual model envelope %0d expected 0 after long decay", m_env);
      end
      for (int i = 0; i < 40; i++) step(0, 0, 0, 1);

      repeat (3) @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule